// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block controls a small direct-mapped cache whose lines hold one data word each and follow a two-state coherence scheme: a line is either Valid or Invalid. The processor side presents one read or write at a time. Reads that hit are answered from the local array without touching the shared bus. Every write, and every read that misses, becomes a single bus transaction. A write allocates the line, so a write to an Invalid line leaves that line Valid with the written word.

A snoop port watches write transactions that other caches place on the shared bus. A snooped address whose index and tag match a Valid line invalidates that line. Snoops are always applied before processor activity in the same cycle. A snoop that arrives together with a new processor request to the same address turns that request into a miss. A snoop that arrives in the cycle a fill completes leaves the line Invalid.

The controller has four states. ST_IDLE accepts a request and performs the lookup. ST_ARB holds a bus request until the grant arrives. ST_XFER presents the command until the bus reports completion. ST_RESP drives a one-cycle response. The transitions are: IDLE→RESP on a read hit; IDLE→ARB on a miss or any write; ARB→XFER on grant; XFER→RESP on completion; RESP→IDLE always.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, cpu_req_ready is 1, and bus_req and cpu_resp_valid are 0. The first read of any address therefore goes to the bus.
- R2: A read accepted while its line is Valid with a matching tag raises cpu_resp_valid in the next cycle, for exactly one cycle, with the stored word. No bus request is raised.
- R3: A write to a Valid line issues a bus write (bus_cmd_write=1) carrying its address and data. The line stays Valid with the new word, so a later read hits and returns that word.
- R4: A read to an Invalid or mismatched line issues a bus read (bus_cmd_write=0). The cycle after bus_done it responds with bus_rdata, and the line becomes Valid with that word.
- R5: A write to an Invalid line issues a bus write. The line then becomes Valid holding the written word, and the response returns the written word.
- R6: A snoop whose address matches a Valid line (same index, same tag) makes that line Invalid from the next cycle on.
- R7: A snoop whose tag differs from the stored tag, or that targets an Invalid line, changes nothing.
- R8: When a snoop and a processor read to the same address arrive in the same cycle, the snoop takes effect first and the read is handled as a miss.
- R9: While a request waits for the bus, cpu_req_ready is 0 and bus_req is 1. bus_cmd_valid rises only in the cycle after bus_gnt. The response waits for bus_done, however long grant and completion take.
- R10: A matching snoop in the same cycle as bus_done for a fill leaves that line Invalid. The processor still receives its response.
- The address splits as index = addr[INDEX_W-1:0] and tag = addr[ADDR_W-1:INDEX_W]. Snoops and processor lookups use the same split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Processor word address |
| cpu_req_wdata | input | DATA_W | Processor write data |
| cpu_req_ready | output | 1 | Request accepted this cycle when high with valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read word, or written word for writes |
| bus_req | output | 1 | Request to the bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_cmd_valid | output | 1 | Bus command being presented |
| bus_cmd_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Bus command address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Bus read return data, sampled with bus_done |
| bus_done | input | 1 | Bus transaction complete |
| snoop_valid | input | 1 | Another cache's write is on the bus |
| snoop_addr | input | ADDR_W | Address of that snooped write |

## Verification
The hardest situations to reach are the two collisions between a snoop and local work. One is a snoop that lands in the very cycle a new request is looked up. The other is a snoop that lands in the exact cycle the bus reports completion of a fill. Both need a snoop to coincide with a specific internal cycle. The bench drives every input on the falling edge and counts cycles from acceptance, so it can raise snoop_valid on the same edge as cpu_req_valid, or on the same edge as bus_done. It then reads the same address again and observes at the bus whether a miss follows.

// File: rtl/wtsc_pkg.sv
package wtsc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_XFER = 2'd2,
        ST_RESP = 2'd3
    } ctl_state_e;
endpackage

// File: rtl/wtsc_match.sv
module wtsc_match #(
    parameter int TAG_W = 13
) (
    input  logic             line_vld,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic             hit
);
    assign hit = line_vld && (line_tag == probe_tag);
endmodule

// File: rtl/wtsc_line_array.sv
module wtsc_line_array #(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 13,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    // processor-side read port
    input  logic [INDEX_W-1:0] cpu_idx,
    output logic               cpu_vld,
    output logic [TAG_W-1:0]   cpu_tag,
    output logic [DATA_W-1:0]  cpu_data,
    // snoop-side read port and invalidate
    input  logic               snp_en,
    input  logic [INDEX_W-1:0] snp_idx,
    input  logic [TAG_W-1:0]   snp_tag,
    input  logic               snp_hit,
    output logic               snp_vld,
    output logic [TAG_W-1:0]   snp_line_tag,
    // fill / update port
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [DATA_W-1:0]  fill_data
);
    localparam int LINES = 1 << INDEX_W;

    logic              vld_q  [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    assign cpu_vld      = vld_q[cpu_idx];
    assign cpu_tag      = tag_q[cpu_idx];
    assign cpu_data     = data_q[cpu_idx];
    assign snp_vld      = vld_q[snp_idx];
    assign snp_line_tag = tag_q[snp_idx];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic fill_here;
        logic kill_here;
        assign fill_here = fill_en && (fill_idx == INDEX_W'(g));
        // snoop wins: kill a present match, or a fill landing this cycle
        assign kill_here = (snp_idx == INDEX_W'(g)) &&
                           (snp_hit || (snp_en && fill_here && (fill_tag == snp_tag)));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g]  <= 1'b0;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else begin
                if (kill_here) begin
                    vld_q[g] <= 1'b0;
                end else if (fill_here) begin
                    vld_q[g] <= 1'b1;
                end
                if (fill_here) begin
                    tag_q[g]  <= fill_tag;
                    data_q[g] <= fill_data;
                end
            end
        end
    end

    // R6: a snoop match seen by the comparator invalidates that line
    assert_snoop_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hit |=> !vld_q[$past(snp_idx)]);

    // R4/R5: an uncontested fill leaves the line valid
    assert_fill_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(snp_en && snp_idx == fill_idx)) |=> vld_q[$past(fill_idx)]);

    // R10: snoop colliding with a fill of the same address leaves line invalid
    assert_fill_snoop_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && snp_en && snp_idx == fill_idx && snp_tag == fill_tag)
            |=> !vld_q[$past(fill_idx)]);
endmodule

// File: rtl/wtsc_fsm.sv
module wtsc_fsm
    import wtsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       lookup_hit,
    input  logic       bus_gnt,
    input  logic       bus_done,
    output ctl_state_e state,
    output logic       accept,
    output logic       hit_accept,
    output logic       fill_en,
    output logic       req_ready,
    output logic       resp_valid,
    output logic       bus_req,
    output logic       bus_cmd_valid
);
    ctl_state_e state_q;
    ctl_state_e state_d;

    assign state = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                         if (!req_write && lookup_hit) state_d = ST_RESP;
                         else                          state_d = ST_ARB;
                     end
            ST_ARB:  if (bus_gnt)  state_d = ST_XFER;
            ST_XFER: if (bus_done) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready     = 1'b0;
        accept        = 1'b0;
        hit_accept    = 1'b0;
        fill_en       = 1'b0;
        resp_valid    = 1'b0;
        bus_req       = 1'b0;
        bus_cmd_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready  = 1'b1;
                accept     = req_valid;
                hit_accept = req_valid && !req_write && lookup_hit;
            end
            ST_ARB:  bus_req = 1'b1;
            ST_XFER: begin
                bus_req       = 1'b1;
                bus_cmd_valid = 1'b1;
                fill_en       = bus_done;
            end
            ST_RESP: resp_valid = 1'b1;
        endcase
    end

    // R2: a response is a single-cycle pulse
    assert_resp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R4: completion on the bus produces a response in the next cycle
    assert_done_to_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_valid && bus_done) |=> resp_valid);
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
    import wtsc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_done,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] cpu_idx, snp_idx, req_idx;
    logic [TAG_W-1:0]   cpu_tag, snp_tag, req_tag;
    assign cpu_idx = cpu_req_addr[INDEX_W-1:0];
    assign cpu_tag = cpu_req_addr[ADDR_W-1:INDEX_W];
    assign snp_idx = snoop_addr[INDEX_W-1:0];
    assign snp_tag = snoop_addr[ADDR_W-1:INDEX_W];

    // captured request
    logic              req_wr_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [DATA_W-1:0] resp_data_q;
    assign req_idx = req_addr_q[INDEX_W-1:0];
    assign req_tag = req_addr_q[ADDR_W-1:INDEX_W];

    logic              line_vld_cpu, line_vld_snp;
    logic [TAG_W-1:0]  line_tag_cpu, line_tag_snp;
    logic [DATA_W-1:0] line_data_cpu;
    logic              cpu_hit_raw, snp_hit, snp_hit_raw, lookup_hit;
    logic              accept, hit_accept, fill_en;
    logic [DATA_W-1:0] fill_data;
    ctl_state_e        state;

    wtsc_match #(.TAG_W(TAG_W)) u_cpu_match (
        .line_vld(line_vld_cpu), .line_tag(line_tag_cpu),
        .probe_tag(cpu_tag), .hit(cpu_hit_raw)
    );

    wtsc_match #(.TAG_W(TAG_W)) u_snp_match (
        .line_vld(line_vld_snp), .line_tag(line_tag_snp),
        .probe_tag(snp_tag), .hit(snp_hit_raw)
    );

    assign snp_hit    = snoop_valid && snp_hit_raw;
    // snoop is applied before the lookup of a request in the same cycle
    assign lookup_hit = cpu_hit_raw && !(snp_hit && (snp_idx == cpu_idx));
    assign fill_data  = req_wr_q ? req_wdata_q : bus_rdata;

    wtsc_line_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .cpu_idx(cpu_idx), .cpu_vld(line_vld_cpu), .cpu_tag(line_tag_cpu),
        .cpu_data(line_data_cpu),
        .snp_en(snoop_valid), .snp_idx(snp_idx), .snp_tag(snp_tag), .snp_hit(snp_hit),
        .snp_vld(line_vld_snp), .snp_line_tag(line_tag_snp),
        .fill_en(fill_en), .fill_idx(req_idx), .fill_tag(req_tag), .fill_data(fill_data)
    );

    wtsc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(cpu_req_valid), .req_write(cpu_req_write), .lookup_hit(lookup_hit),
        .bus_gnt(bus_gnt), .bus_done(bus_done),
        .state(state), .accept(accept), .hit_accept(hit_accept), .fill_en(fill_en),
        .req_ready(cpu_req_ready), .resp_valid(cpu_resp_valid),
        .bus_req(bus_req), .bus_cmd_valid(bus_cmd_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_wr_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            resp_data_q <= '0;
        end else begin
            if (accept) begin
                req_wr_q    <= cpu_req_write;
                req_addr_q  <= cpu_req_addr;
                req_wdata_q <= cpu_req_wdata;
            end
            if (hit_accept)   resp_data_q <= line_data_cpu;
            else if (fill_en) resp_data_q <= fill_data;
        end
    end

    assign cpu_resp_rdata = resp_data_q;
    assign bus_cmd_write  = req_wr_q;
    assign bus_addr       = req_addr_q;
    assign bus_wdata      = req_wdata_q;

    // R2: a read hit completes without involving the bus
    assert_hit_no_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_accept |=> (cpu_resp_valid && !bus_req));

    // R9: waiting for grant holds the request and withholds the command
    assert_hold_for_gnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_cmd_valid && !bus_gnt) |=> (bus_req && !bus_cmd_valid));

    // R9: the command appears only after a grant
    assert_cmd_after_gnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cmd_valid) |-> $past(bus_gnt));

    // R9: no new request is accepted while the bus is in use
    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !cpu_req_ready);

    // R3/R5: every accepted write reaches the bus
    assert_write_goes_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_req_write) |=> bus_req);
endmodule

// File: tb/tb_wt_snoop_ctrl.sv
`timescale 1ns/1ps
module tb_wt_snoop_ctrl;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req_valid = 1'b0;
    logic              cpu_req_write = 1'b0;
    logic [ADDR_W-1:0] cpu_req_addr = '0;
    logic [DATA_W-1:0] cpu_req_wdata = '0;
    logic              cpu_req_ready;
    logic              cpu_resp_valid;
    logic [DATA_W-1:0] cpu_resp_rdata;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic              bus_cmd_valid;
    logic              bus_cmd_write;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic              bus_done = 1'b0;
    logic              snoop_valid = 1'b0;
    logic [ADDR_W-1:0] snoop_addr = '0;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] exp_q [$];
    string             exp_rq [$];

    always #10 clk = ~clk; // 50 MHz

    wt_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(3)) dut (.*);

    task automatic chk(input logic ok, input string rq, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cpu_resp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected response", cpu_resp_rdata, '0);
            end else begin
                logic [DATA_W-1:0] e;
                string r;
                e = exp_q.pop_front();
                r = exp_rq.pop_front();
                chk(cpu_resp_rdata == e, r, "response data", cpu_resp_rdata, e);
            end
        end
    end

    task automatic do_req(input logic wr, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input logic exp_bus,
                          input logic [DATA_W-1:0] brd, input logic [DATA_W-1:0] exp_d,
                          input int gnt_dly, input int done_dly,
                          input logic snp_same, input logic snp_done, input string rq);
        @(negedge clk);
        chk(cpu_req_ready, rq, "ready before request", {31'd0, cpu_req_ready}, 1);
        exp_q.push_back(exp_d);
        exp_rq.push_back(rq);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
        if (snp_same) begin snoop_valid = 1'b1; snoop_addr = a; end
        @(negedge clk);
        cpu_req_valid = 1'b0; snoop_valid = 1'b0;
        chk(bus_req == exp_bus, rq, "bus request after accept", {31'd0, bus_req}, {31'd0, exp_bus});
        if (bus_req) begin
            for (int i = 0; i < gnt_dly; i++) begin
                chk(!bus_cmd_valid && !cpu_req_ready, "R9", "stall before grant",
                    {31'd0, bus_cmd_valid}, 0);
                @(negedge clk);
            end
            bus_gnt = 1'b1;
            @(negedge clk);
            bus_gnt = 1'b0;
            chk(bus_cmd_valid, "R9", "command after grant", {31'd0, bus_cmd_valid}, 1);
            chk(bus_cmd_write == wr, rq, "bus direction", {31'd0, bus_cmd_write}, {31'd0, wr});
            chk(bus_addr == a, rq, "bus address", {16'd0, bus_addr}, {16'd0, a});
            if (wr) chk(bus_wdata == wd, rq, "bus write data", bus_wdata, wd);
            for (int i = 0; i < done_dly; i++) begin
                @(negedge clk);
                chk(bus_cmd_valid && !cpu_resp_valid, "R9", "wait for done",
                    {31'd0, cpu_resp_valid}, 0);
            end
            bus_done = 1'b1; bus_rdata = brd;
            if (snp_done) begin snoop_valid = 1'b1; snoop_addr = a; end
            @(negedge clk);
            bus_done = 1'b0; snoop_valid = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic do_snoop(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = a;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(cpu_req_ready, "R1", "ready in reset", {31'd0, cpu_req_ready}, 1);
        chk(!bus_req && !cpu_resp_valid, "R1", "idle outputs in reset", {31'd0, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_req_ready && !bus_req, "R1", "idle after reset", {31'd0, bus_req}, 0);
        // R1 + R4: first read misses and fills
        do_req(0, 16'h0010, 0, 1, 32'hAAAA0001, 32'hAAAA0001, 0, 0, 0, 0, "R4");
        // R2: read hit
        do_req(0, 16'h0010, 0, 0, 0, 32'hAAAA0001, 0, 0, 0, 0, "R2");
        // R3: write hit goes to the bus, line keeps new word
        do_req(1, 16'h0010, 32'h12345678, 1, 32'hDEAD0000, 32'h12345678, 1, 0, 0, 0, "R3");
        do_req(0, 16'h0010, 0, 0, 0, 32'h12345678, 0, 0, 0, 0, "R3");
        // R5: write miss allocates
        do_req(1, 16'h0023, 32'h00000055, 1, 32'hDEAD0001, 32'h00000055, 0, 1, 0, 0, "R5");
        do_req(0, 16'h0023, 0, 0, 0, 32'h00000055, 0, 0, 0, 0, "R5");
        // R6: matching snoop invalidates
        do_snoop(16'h0010);
        do_req(0, 16'h0010, 0, 1, 32'h0000BEEF, 32'h0000BEEF, 0, 0, 0, 0, "R6");
        // R7: mismatched-tag snoop and snoop to an invalid line are ignored
        do_snoop(16'h0118);
        do_req(0, 16'h0010, 0, 0, 0, 32'h0000BEEF, 0, 0, 0, 0, "R7");
        do_snoop(16'h0004);
        do_req(0, 16'h0023, 0, 0, 0, 32'h00000055, 0, 0, 0, 0, "R7");
        // R8: same-cycle snoop and read to the same address -> miss
        do_req(0, 16'h0023, 0, 1, 32'h0000C0DE, 32'h0000C0DE, 0, 0, 1, 0, "R8");
        // R9: long grant and completion delays
        do_req(0, 16'h0045, 0, 1, 32'h45454545, 32'h45454545, 4, 3, 0, 0, "R9");
        do_req(0, 16'h0045, 0, 0, 0, 32'h45454545, 0, 0, 0, 0, "R9");
        // R10: snoop in the fill-completion cycle leaves the line invalid
        do_req(0, 16'h0031, 0, 1, 32'h31313131, 32'h31313131, 0, 0, 0, 1, "R10");
        do_req(0, 16'h0031, 0, 1, 32'h77777777, 32'h77777777, 0, 0, 0, 0, "R10");
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "responses outstanding", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule